// File: doc/BRIEF.md
# Three-Channel Gated PWM Engine

This block turns three 10-bit brightness levels into three on/off channel enables that share a single 10-bit cycle counter. The counter advances on a selectable tick. The tick is either a base rate derived from the system clock, divided by 1, 2 or 4, or each rising edge of an external serial clock. The counter advances only while an active-low enable input is held low, and it restarts from zero when that enable is released.

Each channel compares its level against the counter. A level of zero stays dark. A full-scale level stays lit, even across the counter's wrap. Any level in between lights the channel for that level plus one counts out of every 1024. A thermal flag darkens all channels while the counter keeps running. An undervoltage flag darkens all channels and holds the counter at zero.

The whole block runs on one system clock. The base rate comes from a one-cycle tick that fires every `BASE_DIV` system cycles.

Top module: `pwm3_engine`

## Requirements
- R1: The counter runs 0, 1, ..., 1023 and then wraps to 0. It steps by exactly one on each selected tick.
- R2: The counter steps only while `oe_n` is low. A rising edge of `oe_n` returns it to 0, and it stays at 0 while `oe_n` is high. The tick divider also restarts, so the first tick arrives one full tick period after `oe_n` falls.
- R3: While `uv_low` is high, all channels are off and the counter and divider are held at 0. After `uv_low` falls, counting restarts from 0.
- R4: Changing any level input does not reset the counter and does not change its value.
- R5: For a level N between 1 and 1022, the channel is on exactly while the counter is at most N. This gives N+1 on-counts out of 1024.
- R6: A level of 0 keeps its channel off for every counter value.
- R7: A level of 1023 keeps its channel on for every counter value, including across the wrap.
- R8: `clk_mode` 00 ticks every `BASE_DIV` system cycles. 01 ticks every 2×`BASE_DIV` cycles. 11 ticks every 4×`BASE_DIV` cycles.
- R9: `clk_mode` 10 advances the counter once per rising edge of `ext_clk`, as sampled on the system clock. It ignores the base tick. Holding `ext_clk` high adds no further counts.
- R10: While `oe_n` is high, all channel outputs are 0.
- R11: While `thermal_hot` is high, all outputs are 0 and the counter keeps stepping. After `thermal_hot` falls, the outputs match the running count with no reload.
- R12: Under reset the counter is 0. With `oe_n` low, a channel is then on exactly when its level is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| level | input | NCH*CW | Brightness levels; channel i occupies bits [i*CW +: CW] |
| clk_mode | input | 2 | Tick source: 00 base, 01 half, 11 quarter, 10 external |
| oe_n | input | 1 | Active-low run enable; releasing it restarts the count |
| ext_clk | input | 1 | External serial clock, sampled synchronously |
| thermal_hot | input | 1 | Thermal flag: blanks outputs only |
| uv_low | input | 1 | Undervoltage flag: blanks outputs and holds the counter at 0 |
| ch_on | output | NCH | Channel on/off enables |

## Verification
Two events can land on the same system cycle: the enable's restart edge and a tick that is ready to step the counter. The bench releases `oe_n` in the cycle just before a pending base tick. It then lowers `oe_n` again and judges the result from when the channels go dark: the new window must start from zero, with no extra count. A second pair is a level rewrite that coincides with a counter step, in the middle of a sweep. Each output sample is compared with the value computed from the cycle index, so any counter reset or slip shows up as a mismatch on the following samples.

// File: rtl/pwm3_engine.sv
module pwm3_engine #(
  parameter int CW       = 10,
  parameter int NCH      = 3,
  parameter int BASE_DIV = 50
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NCH*CW-1:0]  level,
  input  logic [1:0]         clk_mode,
  input  logic               oe_n,
  input  logic               ext_clk,
  input  logic               thermal_hot,
  input  logic               uv_low,
  output logic [NCH-1:0]     ch_on
);
  localparam int DW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(BASE_DIV - 1);
  localparam logic [1:0] M_BASE = 2'b00, M_HALF = 2'b01, M_EXT = 2'b10, M_QUART = 2'b11;

  logic [DW-1:0] bdiv;
  logic [1:0]    pre;
  logic [CW-1:0] cnt;
  logic          oe_q, ext_q;
  logic          base_tick, tick, oe_rise, ext_rise, hold;

  assign hold      = oe_n | uv_low;
  assign base_tick = ~hold & (bdiv == DIV_LAST);
  assign oe_rise   = oe_n & ~oe_q;
  assign ext_rise  = ext_clk & ~ext_q;

  always_comb begin
    case (clk_mode)
      M_BASE:  tick = base_tick;
      M_HALF:  tick = base_tick & pre[0];
      M_QUART: tick = base_tick & (pre == 2'b11);
      M_EXT:   tick = ext_rise;
      default: tick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bdiv  <= '0;
      pre   <= '0;
      oe_q  <= 1'b1;
      ext_q <= 1'b0;
    end else begin
      oe_q  <= oe_n;
      ext_q <= ext_clk;
      if (hold) begin
        bdiv <= '0;
        pre  <= '0;
      end else if (base_tick) begin
        bdiv <= '0;
        pre  <= pre + 2'd1;
      end else begin
        bdiv <= bdiv + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (uv_low || oe_rise) cnt <= '0;
    else if (!oe_n && tick)     cnt <= cnt + CW'(1);
  end

  logic run_ok;
  assign run_ok = ~oe_n & ~thermal_hot & ~uv_low;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [CW-1:0] lv;
    assign lv       = level[i*CW +: CW];
    assign ch_on[i] = run_ok & (lv != '0) & (cnt <= lv);
  end
endmodule

module pwm3_engine_chk #(
  parameter int CW  = 10,
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH*CW-1:0] level,
  input logic              oe_n,
  input logic              thermal_hot,
  input logic              uv_low,
  input logic [CW-1:0]     cnt,
  input logic [NCH-1:0]    ch_on
);
  a_r10_dark_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> ch_on == '0);
  a_r11_dark_when_hot: assert property (@(posedge clk) disable iff (!rst_n)
    thermal_hot |-> ch_on == '0);
  a_r3_uv_dark: assert property (@(posedge clk) disable iff (!rst_n)
    uv_low |-> ch_on == '0);
  a_r3_uv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    uv_low |=> cnt == '0);
  a_r2_held_zero: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |=> cnt == '0);
  a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !uv_low) |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1)));
  a_r7_full_on: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_n && !thermal_hot && !uv_low && level[CW-1:0] == {CW{1'b1}}) |-> ch_on[0]);
  a_r6_zero_off: assert property (@(posedge clk) disable iff (!rst_n)
    (level[CW-1:0] == '0) |-> !ch_on[0]);
endmodule

bind pwm3_engine pwm3_engine_chk #(.CW(CW), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .level(level), .oe_n(oe_n),
  .thermal_hot(thermal_hot), .uv_low(uv_low), .cnt(cnt), .ch_on(ch_on)
);

// File: tb/pwm3_engine_test.sv
module pwm3_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 10;
  localparam int NCH = 3;
  localparam int DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH*CW-1:0] level = '0;
  logic [1:0] clk_mode = 2'b00;
  logic oe_n = 1'b0, ext_clk = 1'b0, hot = 1'b0, uv = 1'b0;
  logic [NCH-1:0] ch_on;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm3_engine #(.CW(CW), .NCH(NCH), .BASE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .level(level), .clk_mode(clk_mode), .oe_n(oe_n),
    .ext_clk(ext_clk), .thermal_hot(hot), .uv_low(uv), .ch_on(ch_on)
  );

  function automatic logic [NCH*CW-1:0] pack(input int a, input int b, input int c);
    return {CW'(c), CW'(b), CW'(a)};
  endfunction

  function automatic logic [NCH-1:0] expect_on(input int c);
    logic [NCH-1:0] e;
    for (int i = 0; i < NCH; i++) begin
      int b;
      b = int'(level[i*CW +: CW]);
      e[i] = !hot && !uv && !oe_n && b != 0 && c <= b;
    end
    return e;
  endfunction

  task automatic check_ch(input logic [NCH-1:0] exp, input string req);
    checks++;
    if (ch_on !== exp) begin
      fails++;
      $display("FAIL %s: ch_on=%b expected %b at %0t", req, ch_on, exp, $time);
    end
  endtask

  task automatic restart(input logic [1:0] m);
    @(negedge clk);
    clk_mode = m;
    oe_n = 1'b1;
    @(negedge clk);
    check_ch('0, "R10");
    oe_n = 1'b0;
    #1 check_ch(expect_on(0), "R2");
  endtask

  task automatic sweep(input int n, input int per, input int hot_lo, input int hot_hi,
                       input int sw_at, input logic [NCH*CW-1:0] nxt, input string req);
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      check_ch(expect_on((k / per) % 1024), req);
      if (k == hot_lo) hot = 1'b1;
      if (k == hot_hi) hot = 1'b0;
      if (k == sw_at)  level = nxt;
    end
  endtask

  task automatic ext_pulse();
    @(negedge clk); ext_clk = 1'b1;
    @(negedge clk); @(negedge clk); @(negedge clk);
    ext_clk = 1'b0;
  endtask

  initial begin
    oe_n = 1'b0;
    level = pack(0, 3, 1023);
    #(CLK_PERIOD*3);
    check_ch(3'b110, "R12");
    @(negedge clk); rst_n = 1'b1;

    level = pack(1, 0, 1023);
    restart(2'b00);
    sweep(2100, DIV, 300, 340, 1500, pack(512, 5, 1022), "R1 R4 R5 R6 R7 R11 R8");

    level = pack(3, 700, 1022);
    restart(2'b01);
    sweep(2200, 2*DIV, -1, -1, -1, '0, "R8 R5");

    level = pack(1023, 100, 9);
    restart(2'b11);
    sweep(8250, 4*DIV, 4000, 4010, -1, '0, "R8 R7 R1");

    level = pack(4, 1, 6);
    restart(2'b00);
    sweep(9, DIV, -1, -1, -1, '0, "R5");
    @(negedge clk); uv = 1'b1;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk); check_ch('0, "R3");
    end
    uv = 1'b0;
    #1 check_ch(expect_on(0), "R3");
    sweep(30, DIV, -1, -1, -1, '0, "R3");

    restart(2'b00);
    sweep(5, DIV, -1, -1, -1, '0, "R2");
    @(negedge clk); oe_n = 1'b1;
    for (int j = 0; j < 40; j++) begin
      @(negedge clk); check_ch('0, "R10");
    end
    oe_n = 1'b0;
    sweep(16, DIV, -1, -1, -1, '0, "R2");

    level = pack(2, 0, 1023);
    restart(2'b10);
    ext_pulse();
    for (int j = 0; j < 20; j++) @(negedge clk);
    check_ch(3'b101, "R9");
    ext_pulse();
    check_ch(3'b101, "R9");
    ext_pulse();
    check_ch(3'b100, "R9");

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD*190000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL R1 watchdog: run still active, expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule